// File: doc/BRIEF.md
# Clock Synthesizer Parameter Registers with Ordered Commit

This block holds the three loop-parameter registers of a clock synthesizer behind a two-port indexed I/O window. The host first writes an 8-bit register number to the index port and then reads or writes the chosen register through the data port. Every data write lands in a shadow copy. The synthesizer-facing parameters change only when the three registers have been written in ascending order: first the low register (index CCh), then the middle one (CDh), then the top one (CEh). No separate strobe or commit register is needed. As a result, the synthesizer never sees a mix of old and new values.

The top register (CEh) carries two fields. Bit 7 chooses between the fixed default preset clock (0) and the programmed loop (1). Bits 6:4 hold a post-divider code, which the block decodes into a divide ratio. A sequence tracker watches the order of data writes. When a commit happens, both active parameter bytes, the decoded ratio, the invalid-code flag and a one-cycle update pulse all change on the same clock edge. Software is expected to drop bit 7 back to 0 before it reprograms the other fields.

Top module: `clksyn_param_regs`

## Requirements
- R1: A write with `io_sel`=0 loads the index register. A read with `io_sel`=0 returns that index. A data access (`io_sel`=1) targets the register named by the index. Read data appears on `io_rdata` one clock after the read cycle and holds until the next read.
- R2: A data write to CCh, CDh or CEh updates only the shadow copy. `loop_a`, `loop_b`, `div_ratio` and `div_bad` keep their values on every cycle without a commit.
- R3: A data write to CEh commits when the two writes to the block just before it went to CCh and then CDh. On that clock edge, `loop_a` takes the CCh shadow, `loop_b` takes the CDh shadow, the post-divider outputs take the decode of the written bits 6:4, and `upd_pulse` rises.
- R4: A write to CCh always restarts the sequence. A write to CDh that does not follow CCh, or a write to CEh that does not follow CDh, cancels the sequence and commits nothing. The shadow copy is still stored.
- R5: `src_prog` equals bit 7 of the most recent CEh write from the clock after that write, whether or not the write commits.
- R6: The post-divider codes decode as follows: 000 gives ratio 1, 001 gives 2, 010 gives 4, 011 gives 8, 100 gives 16 and 101 gives 32.
- R7: A reserved code (110 or 111) still commits. It drives `div_ratio`=0 and `div_bad`=1. A valid code drives `div_bad`=0.
- R8: Bits 3:0 of the CEh register always read as 0, whatever value was written to them.
- R9: A data read of any index outside CCh..CEh returns 00h. A data write there changes no register and does not change the sequence state.
- R10: After reset, all shadow and active bytes are 0, `div_ratio` is 1, `div_bad`, `src_prog` and `upd_pulse` are 0, and the sequence starts over.
- R11: `upd_pulse` is high for exactly one cycle per commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host write strobe, one per clock cycle |
| io_rd | input | 1 | Host read strobe |
| io_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| loop_a | output | 8 | Active low loop parameter (CCh) |
| loop_b | output | 8 | Active middle loop parameter (CDh) |
| div_ratio | output | 6 | Active decoded post-divider ratio, 0 when the code is reserved |
| div_bad | output | 1 | Active post-divider code is reserved |
| src_prog | output | 1 | 1 selects the programmed loop, 0 selects the preset clock |
| upd_pulse | output | 1 | One-cycle pulse marking a commit |

## Verification
The bench targets the sequence tracker's edge cases:
- CEh written directly after CCh, skipping CDh.
- CDh written while the tracker is idle.
- CCh written twice in a row, where the second write must restart the sequence.
- A write to an unrelated index in the middle of a sequence. A tracker that reset on any write would miss this commit, and one that ignored order would commit early.

It also commits a reserved divider code and checks both ends of the ratio table. A decoder that clamped or wrapped the code would show the wrong ratio or no invalid flag. Readback checks cover the always-zero low nibble, out-of-range indices, and a shadow write that must not reach the active outputs.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int NREG = 3;
  typedef enum logic [1:0] {SQ_IDLE, SQ_GOT_A, SQ_GOT_B} seq_t;
endpackage

// File: rtl/clksyn_index.sv
module clksyn_index #(
  parameter int IDX_W    = 8,
  parameter int NREG     = 3,
  parameter int BASE_IDX = 'hCC,
  localparam int SLOT_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_sel,
  input  logic [IDX_W-1:0]  io_wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              in_range,
  output logic [SLOT_W-1:0] slot,
  output logic [NREG-1:0]   wr_hit
);
  localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE_IDX);
  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(BASE_IDX + NREG - 1);

  logic [IDX_W-1:0] off;

  always_ff @(posedge clk) begin
    if (rst)                  idx_q <= '0;
    else if (io_wr && !io_sel) idx_q <= io_wdata;
  end

  always_comb begin
    off      = idx_q - BASE_V;
    in_range = (idx_q >= BASE_V) && (idx_q <= LAST_V);
    slot     = off[SLOT_W-1:0];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = io_wr && io_sel && in_range && (slot == SLOT_W'(i));
  end

  // R9: a data write outside the window reaches no register
  assert_no_stray_hit_R9: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> (wr_hit == '0));
  assert_onehot_hit_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));
endmodule

// File: rtl/clksyn_seq.sv
module clksyn_seq #(
  parameter int NREG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREG-1:0]  wr_hit,
  output logic             commit,
  output clksyn_pkg::seq_t state
);
  import clksyn_pkg::*;

  seq_t nxt;

  always_comb begin
    nxt    = state;
    commit = 1'b0;
    if (wr_hit[0]) begin
      nxt = SQ_GOT_A;
    end else if (wr_hit[1]) begin
      nxt = (state == SQ_GOT_A) ? SQ_GOT_B : SQ_IDLE;
    end else if (wr_hit[NREG-1]) begin
      commit = (state == SQ_GOT_B);
      nxt    = SQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= nxt;
  end

  // R4: every top-register write leaves the tracker idle
  assert_top_write_idles_R4: assert property (@(posedge clk) disable iff (rst)
    wr_hit[NREG-1] |=> (state == SQ_IDLE));
  // R4: a low-register write always restarts the sequence
  assert_low_restarts_R4: assert property (@(posedge clk) disable iff (rst)
    wr_hit[0] |=> (state == SQ_GOT_A));
  // R9: no hit leaves the state alone
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit == '0) |=> $stable(state));
endmodule

// File: rtl/clksyn_div.sv
module clksyn_div #(
  parameter int CODE_W  = 3,
  parameter int RATIO_W = 6
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio,
  output logic               bad
);
  always_comb begin
    bad   = (int'(code) >= RATIO_W);
    ratio = bad ? '0 : (RATIO_W'(1) << code);
  end
endmodule

// File: rtl/clksyn_param_regs.sv
module clksyn_param_regs #(
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int BASE_IDX = 'hCC,
  parameter int SEL_BIT  = 7,
  parameter int DIV_LSB  = 4,
  parameter int DIV_W    = 3,
  parameter int RATIO_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic               io_sel,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic [DATA_W-1:0]  io_rdata,
  output logic [DATA_W-1:0]  loop_a,
  output logic [DATA_W-1:0]  loop_b,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               div_bad,
  output logic               src_prog,
  output logic               upd_pulse
);
  import clksyn_pkg::*;

  localparam int SLOT_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int TOP    = NREG - 1;
  localparam logic [DATA_W-1:0] TOP_MASK = ~((DATA_W'(1) << DIV_LSB) - DATA_W'(1));

  logic [IDX_W-1:0]   idx_q;
  logic               in_range;
  logic [SLOT_W-1:0]  slot;
  logic [NREG-1:0]    wr_hit;
  logic               commit;
  seq_t               sq_state;
  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_bad;
  logic [DATA_W-1:0]  shadow [NREG];
  logic [DATA_W-1:0]  rd_sel;

  clksyn_index #(.IDX_W(IDX_W), .NREG(NREG), .BASE_IDX(BASE_IDX)) u_index (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_sel(io_sel),
    .io_wdata(io_wdata[IDX_W-1:0]), .idx_q(idx_q), .in_range(in_range),
    .slot(slot), .wr_hit(wr_hit)
  );

  clksyn_seq #(.NREG(NREG)) u_seq (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .commit(commit), .state(sq_state)
  );

  clksyn_div #(.CODE_W(DIV_W), .RATIO_W(RATIO_W)) u_div (
    .code(io_wdata[DIV_LSB +: DIV_W]), .ratio(dec_ratio), .bad(dec_bad)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_shadow
    localparam logic [DATA_W-1:0] MASK = (i == TOP) ? TOP_MASK : '1;
    always_ff @(posedge clk) begin
      if (rst)            shadow[i] <= '0;
      else if (wr_hit[i]) shadow[i] <= io_wdata & MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_a    <= '0;
      loop_b    <= '0;
      div_ratio <= RATIO_W'(1);
      div_bad   <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= commit;
      if (commit) begin
        loop_a    <= shadow[0];
        loop_b    <= shadow[1];
        div_ratio <= dec_ratio;
        div_bad   <= dec_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              src_prog <= 1'b0;
    else if (wr_hit[TOP]) src_prog <= io_wdata[SEL_BIT];
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++)
      if (in_range && slot == SLOT_W'(i)) rd_sel = shadow[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= io_sel ? rd_sel : DATA_W'(idx_q);
  end

  // R2: active parameters move only on an update cycle
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |-> $stable({loop_a, loop_b, div_ratio, div_bad}));
  // R3: the committed middle byte is the shadow value
  assert_commit_match_R3: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (loop_b == shadow[1]) && (loop_a == shadow[0]));
  // R11: update pulse lasts one cycle
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);
  // R7: a reserved code yields a zero ratio
  assert_bad_zero_R7: assert property (@(posedge clk) disable iff (rst)
    div_bad |-> (div_ratio == '0));
  // R6: a valid ratio is a single power of two
  assert_ratio_pow2_R6: assert property (@(posedge clk) disable iff (rst)
    !div_bad |-> $onehot0(div_ratio) && (div_ratio != '0));
  // R8: reserved low bits of the top register read back as zero
  assert_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(io_rd && io_sel && in_range && slot == SLOT_W'(TOP))
      |-> ((io_rdata & ~TOP_MASK) == '0));
endmodule

// File: tb/clksyn_param_regs_tb.sv
module clksyn_param_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, loop_a, loop_b;
  logic [5:0] div_ratio;
  logic       div_bad, src_prog, upd_pulse;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clksyn_param_regs u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .loop_a(loop_a), .loop_b(loop_b),
    .div_ratio(div_ratio), .div_bad(div_bad), .src_prog(src_prog),
    .upd_pulse(upd_pulse)
  );

  // {index, data, pulse, loop_a, loop_b, ratio, bad, src}
  localparam int NV = 27;
  localparam logic [40:0] VEC [NV] = '{
    {8'hCC,8'h12,1'b0,8'h00,8'h00,6'd1 ,1'b0,1'b0},
    {8'hCD,8'h34,1'b0,8'h00,8'h00,6'd1 ,1'b0,1'b0},
    {8'hCE,8'h95,1'b1,8'h12,8'h34,6'd2 ,1'b0,1'b1},
    {8'hCD,8'h56,1'b0,8'h12,8'h34,6'd2 ,1'b0,1'b1},
    {8'hCE,8'h20,1'b0,8'h12,8'h34,6'd2 ,1'b0,1'b0},
    {8'hCC,8'h77,1'b0,8'h12,8'h34,6'd2 ,1'b0,1'b0},
    {8'hCC,8'h78,1'b0,8'h12,8'h34,6'd2 ,1'b0,1'b0},
    {8'hCD,8'h9A,1'b0,8'h12,8'h34,6'd2 ,1'b0,1'b0},
    {8'hCE,8'hC0,1'b1,8'h78,8'h9A,6'd16,1'b0,1'b1},
    {8'hCC,8'h01,1'b0,8'h78,8'h9A,6'd16,1'b0,1'b1},
    {8'hCE,8'h80,1'b0,8'h78,8'h9A,6'd16,1'b0,1'b1},
    {8'hCD,8'h02,1'b0,8'h78,8'h9A,6'd16,1'b0,1'b1},
    {8'hCE,8'h50,1'b0,8'h78,8'h9A,6'd16,1'b0,1'b0},
    {8'hCC,8'h11,1'b0,8'h78,8'h9A,6'd16,1'b0,1'b0},
    {8'hCD,8'h22,1'b0,8'h78,8'h9A,6'd16,1'b0,1'b0},
    {8'hCE,8'hE3,1'b1,8'h11,8'h22,6'd0 ,1'b1,1'b1},
    {8'hCC,8'h33,1'b0,8'h11,8'h22,6'd0 ,1'b1,1'b1},
    {8'hCD,8'h44,1'b0,8'h11,8'h22,6'd0 ,1'b1,1'b1},
    {8'hCE,8'h50,1'b1,8'h33,8'h44,6'd32,1'b0,1'b0},
    {8'h3F,8'h99,1'b0,8'h33,8'h44,6'd32,1'b0,1'b0},
    {8'hCC,8'h55,1'b0,8'h33,8'h44,6'd32,1'b0,1'b0},
    {8'h10,8'hAA,1'b0,8'h33,8'h44,6'd32,1'b0,1'b0},
    {8'hCD,8'h66,1'b0,8'h33,8'h44,6'd32,1'b0,1'b0},
    {8'hCE,8'h30,1'b1,8'h55,8'h66,6'd8 ,1'b0,1'b0},
    {8'hCC,8'h00,1'b0,8'h55,8'h66,6'd8 ,1'b0,1'b0},
    {8'hCD,8'h00,1'b0,8'h55,8'h66,6'd8 ,1'b0,1'b0},
    {8'hCE,8'h80,1'b1,8'h00,8'h00,6'd1 ,1'b0,1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    io_wr = 1'b1; io_sel = s; io_wdata = d;
    @(posedge clk); #2;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic s);
    io_rd = 1'b1; io_sel = s;
    @(posedge clk); #2;
    io_rd = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    // R10 reset state
    chk("R10 loop_a", loop_a, 8'h00);
    chk("R10 loop_b", loop_b, 8'h00);
    chk("R10 ratio", div_ratio, 6'd1);
    chk("R10 bad", div_bad, 1'b0);
    chk("R10 src", src_prog, 1'b0);
    chk("R10 pulse", upd_pulse, 1'b0);
    chk("R10 rdata", io_rdata, 8'h00);

    // R2 R3 R4 R5 R6 R7 R9 R11 vector walk
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VEC[v][40:33]);
      wr(1'b1, VEC[v][32:25]);
      chk("R3 pulse", upd_pulse, VEC[v][24]);
      chk("R2 loop_a", loop_a, VEC[v][23:16]);
      chk("R2 loop_b", loop_b, VEC[v][15:8]);
      chk("R6 ratio", div_ratio, VEC[v][7:2]);
      chk("R7 bad", div_bad, VEC[v][1]);
      chk("R5 src", src_prog, VEC[v][0]);
      if (VEC[v][24]) begin
        @(posedge clk); #2;
        chk("R11 pulse drop", upd_pulse, 1'b0);
      end
    end

    // R1 index readback, then shadow readback
    rd(1'b0);
    chk("R1 index read", io_rdata, 8'hCE);
    rd(1'b1);
    chk("R1 data read", io_rdata, 8'h80);
    // R8 low nibble zero
    wr(1'b1, 8'h8F);
    rd(1'b1);
    chk("R8 low bits", io_rdata, 8'h80);
    // R4 lone shadow write reaches readback only
    wr(1'b0, 8'hCD);
    wr(1'b1, 8'h5A);
    rd(1'b1);
    chk("R4 shadow stored", io_rdata, 8'h5A);
    chk("R4 no commit", loop_b, 8'h00);
    chk("R4 no pulse", upd_pulse, 1'b0);
    // R9 out-of-range read
    wr(1'b0, 8'h3F);
    rd(1'b1);
    chk("R9 stray read", io_rdata, 8'h00);
    wr(1'b0, 8'hCB);
    rd(1'b1);
    chk("R9 below window", io_rdata, 8'h00);

    // R10 reset after activity
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    chk("R10 src after reset", src_prog, 1'b0);
    wr(1'b0, 8'hCD);
    rd(1'b1);
    chk("R10 shadow cleared", io_rdata, 8'h00);
    summary();
  end
endmodule